// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Arbiter

This block keeps a 1024-row DRAM refreshed within its 16 ms retention window. A clock-cycle interval timer expires about every 15.6 µs and adds one owed refresh to a backlog counter. Whenever the access sequencer reports that it is idle with its page closed, the arbiter takes the DRAM bus and runs one refresh cycle for each owed refresh, one after another.

Two refresh styles are available. In CAS-first style, all CAS lines fall before RAS, write-enable stays high and the DRAM steps its own internal row counter. In RAS-only style, CAS stays high, the block drives its own 10-bit row counter onto the address bus and pulses RAS alone. After each such cycle the counter advances and wraps to zero after 1023. The backlog is capped. When the cap is reached, the block asks the sequencer to close its open page. If the timer expires again while the backlog is full, the block sets a sticky overflow flag.

Each refresh cycle has three phases: a setup phase, a RAS-low phase and a precharge phase. The length of each phase is a parameter in clock cycles. The defaults at 125 MHz give 8 ns of CAS-to-RAS setup, 56 ns of RAS low and 32 ns of precharge, for a 96 ns cycle. These meet the device minimums of 5 ns, 50 ns, 30 ns and an 84 ns cycle.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, the outputs are: rasN=1, casN=all ones, weN=1, addr=0, pendCount=0, refBusy=0, closeReq=0 and ovfErr=0.
- R2: With no refresh starting, pendCount rises by one at every INTERVAL_CYC-th rising clock edge after reset is released. The first rise is at edge INTERVAL_CYC.
- R3: pendCount never exceeds PEND_MAX. A timer expiry that arrives while the count is at PEND_MAX and no refresh starts leaves the count unchanged.
- R4: ovfErr goes to 1 at a timer expiry that finds pendCount at PEND_MAX with no refresh starting in that cycle. Once set, ovfErr stays at 1 until reset.
- R5: A refresh starts only at a clock edge where seqIdle=1, pendCount>0 and no refresh is running. Starting lowers pendCount by one from the next cycle on. refBusy is then high for SETUP_CYC+RASLO_CYC+PRECH_CYC cycles in a row.
- R6: closeReq is 1 exactly when pendCount equals PEND_MAX and no refresh is running.
- R7: With refMode=0 (CAS-first style):
  - the first SETUP_CYC busy cycles have every casN bit at 0 and rasN at 1;
  - rasN is then 0 for RASLO_CYC cycles with casN still all zero;
  - weN stays 1 and addr stays 0 for the whole cycle.
- R8: With refMode=1 (RAS-only style), casN stays all ones for the whole busy window. rasN is 0 for RASLO_CYC cycles, and addr carries the row counter while rasN is low.
- R9: The row counter starts at 0 after reset. It advances by one after each RAS-only refresh and wraps from 1023 to 0. A CAS-first refresh does not change it.
- R10: refMode is taken at the edge where a refresh starts. Changing refMode while refBusy is high does not change the style of that refresh or whether it advances the row counter.
- R11: Owed refreshes are served one at a time. Each completes its precharge phase before the next setup phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refMode | input | 1 | Refresh style: 0 = CAS-first, 1 = RAS-only |
| seqIdle | input | 1 | Access sequencer is idle with its page closed |
| refBusy | output | 1 | Refresh owns the DRAM bus |
| closeReq | output | 1 | Backlog full: sequencer must close its page |
| rasN | output | 1 | Row strobe, active low |
| casN | output | CAS_LINES | Column strobes, active low |
| weN | output | 1 | Write enable, active low (held high) |
| addr | output | ROW_BITS | Row address during RAS-only refresh |
| pendCount | output | $clog2(PEND_MAX+1) | Number of owed refreshes |
| ovfErr | output | 1 | Sticky backlog overflow flag |

## Verification
Each result has a fixed due cycle:

| Result | When it is due |
|---|---|
| pendCount after a timer expiry | right after rising edge INTERVAL_CYC counted from reset release |
| refBusy and the lowered pendCount | one edge after the edge that sees seqIdle high with work owed |
| bus pins (rasN, casN, addr) | combinational from the sequence state, so they change with refBusy |
| ovfErr | at the same edge as the overflowing expiry |

The bench drives inputs and samples outputs only on falling edges. It counts rising edges from reset release to land on the cycle where each count is due, checking one edge before it as well. It then measures each refresh's busy and RAS-low lengths cycle by cycle against the phase parameters.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Refresh sequence phases
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RASLO,
    ST_PRECH
  } seq_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic consume;   // a refresh starts this cycle: take one owed refresh
    logic rowStep;   // advance the controller row counter
  } ctl_strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic pendAny;   // at least one refresh owed
    logic pendFull;  // backlog at its cap
  } dp_status_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int INTERVAL_CYC = 1950,
  parameter int PEND_MAX     = 8,
  parameter int ROW_BITS     = 10,
  localparam int PEND_W      = $clog2(PEND_MAX + 1),
  localparam int TMR_W       = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_strobe_t         strobe,
  output dp_status_t          status,
  output logic [PEND_W-1:0]   pendCount,
  output logic [ROW_BITS-1:0] rowAddr,
  output logic                ovfErr
);

  localparam logic [TMR_W-1:0]  TMR_RELOAD = TMR_W'(INTERVAL_CYC - 1);
  localparam logic [PEND_W-1:0] PEND_CAP   = PEND_W'(PEND_MAX);

  logic [TMR_W-1:0]    tmrCnt;
  logic                tmrTick;
  logic [PEND_W-1:0]   pendCnt;
  logic [PEND_W-1:0]   pendNext;
  logic [ROW_BITS-1:0] rowCnt;
  logic                errFlag;

  // Interval down-counter
  assign tmrTick = (tmrCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) tmrCnt <= TMR_RELOAD;
    else if (tmrTick) tmrCnt <= TMR_RELOAD;
    else tmrCnt <= tmrCnt - 1'b1;
  end

  // Backlog counter
  always_comb begin
    pendNext = pendCnt;
    if (tmrTick && !strobe.consume) begin
      if (pendCnt != PEND_CAP) pendNext = pendCnt + 1'b1;
    end else if (!tmrTick && strobe.consume) begin
      pendNext = pendCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= '0;
    else pendCnt <= pendNext;
  end

  // Sticky overflow
  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else if (tmrTick && (pendCnt == PEND_CAP) && !strobe.consume) errFlag <= 1'b1;
  end

  // Controller row counter
  always_ff @(posedge clk) begin
    if (!rstN) rowCnt <= '0;
    else if (strobe.rowStep) rowCnt <= rowCnt + 1'b1;
  end

  assign status.pendAny  = (pendCnt != '0);
  assign status.pendFull = (pendCnt == PEND_CAP);
  assign pendCount = pendCnt;
  assign rowAddr   = rowCnt;
  assign ovfErr    = errFlag;

  // R3
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_CAP);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rowCnt) |-> rowCnt == ROW_BITS'($past(rowCnt) + 1'b1));

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RASLO_CYC = 7,
  parameter int PRECH_CYC = 4,
  parameter int CAS_LINES = 4,
  parameter int ROW_BITS  = 10,
  localparam int PH_MAX   = (SETUP_CYC > RASLO_CYC)
                            ? ((SETUP_CYC > PRECH_CYC) ? SETUP_CYC : PRECH_CYC)
                            : ((RASLO_CYC > PRECH_CYC) ? RASLO_CYC : PRECH_CYC),
  localparam int PH_W     = $clog2(PH_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refMode,
  input  logic                 seqIdle,
  input  dp_status_t           status,
  input  logic [ROW_BITS-1:0]  rowAddr,
  output ctl_strobe_t          strobe,
  output logic                 rasN,
  output logic [CAS_LINES-1:0] casN,
  output logic                 weN,
  output logic [ROW_BITS-1:0]  addr,
  output logic                 refBusy,
  output logic                 closeReq
);

  seq_state_e    state, stateNext;
  logic [PH_W-1:0] phase, phaseNext;
  logic          modeLat;   // 1 = RAS-only for the running refresh
  logic          grant;
  logic          phaseEnd;

  assign phaseEnd = (phase == '0);
  assign grant    = (state == ST_IDLE) && status.pendAny && seqIdle;

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    unique case (state)
      ST_IDLE: if (grant) begin
        stateNext = ST_SETUP;
        phaseNext = PH_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (phaseEnd) begin
        stateNext = ST_RASLO;
        phaseNext = PH_W'(RASLO_CYC - 1);
      end else phaseNext = phase - 1'b1;
      ST_RASLO: if (phaseEnd) begin
        stateNext = ST_PRECH;
        phaseNext = PH_W'(PRECH_CYC - 1);
      end else phaseNext = phase - 1'b1;
      ST_PRECH: if (phaseEnd) stateNext = ST_IDLE;
                else phaseNext = phase - 1'b1;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      modeLat <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
      if (grant) modeLat <= refMode;
    end
  end

  assign strobe.consume = grant;
  assign strobe.rowStep = (state == ST_RASLO) && phaseEnd && modeLat;

  // Bus pins
  always_comb begin
    rasN = (state != ST_RASLO);
    casN = '1;
    if (!modeLat && ((state == ST_SETUP) || (state == ST_RASLO))) casN = '0;
    weN  = 1'b1;
    addr = (modeLat && (state != ST_IDLE)) ? rowAddr : '0;
  end

  assign refBusy  = (state != ST_IDLE);
  assign closeReq = status.pendFull && (state == ST_IDLE);

  // R5
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refBusy) |-> $past(seqIdle) && $past(status.pendAny));

  // R7
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !modeLat) |-> ($past(casN) == '0) && (casN == '0));

  // R8
  rasonly_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refBusy && modeLat) |-> casN == '1);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refBusy && $past(refBusy)) |-> $stable(modeLat));

  // R6
  close_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    closeReq |-> !refBusy);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int INTERVAL_CYC = 1950,
  parameter int PEND_MAX     = 8,
  parameter int ROW_BITS     = 10,
  parameter int CAS_LINES    = 4,
  parameter int SETUP_CYC    = 1,
  parameter int RASLO_CYC    = 7,
  parameter int PRECH_CYC    = 4,
  localparam int PEND_W      = $clog2(PEND_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refMode,
  input  logic                 seqIdle,
  output logic                 refBusy,
  output logic                 closeReq,
  output logic                 rasN,
  output logic [CAS_LINES-1:0] casN,
  output logic                 weN,
  output logic [ROW_BITS-1:0]  addr,
  output logic [PEND_W-1:0]    pendCount,
  output logic                 ovfErr
);

  ctl_strobe_t         strobe;
  dp_status_t          status;
  logic [ROW_BITS-1:0] rowAddr;

  refresh_dp #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .PEND_MAX    (PEND_MAX),
    .ROW_BITS    (ROW_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .status   (status),
    .pendCount(pendCount),
    .rowAddr  (rowAddr),
    .ovfErr   (ovfErr)
  );

  refresh_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .RASLO_CYC(RASLO_CYC),
    .PRECH_CYC(PRECH_CYC),
    .CAS_LINES(CAS_LINES),
    .ROW_BITS (ROW_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .refMode (refMode),
    .seqIdle (seqIdle),
    .status  (status),
    .rowAddr (rowAddr),
    .strobe  (strobe),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .addr    (addr),
    .refBusy (refBusy),
    .closeReq(closeReq)
  );

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;

  localparam int INTERVAL = 20;
  localparam int PMAX     = 8;
  localparam int SETUPC   = 1;
  localparam int RASLOC   = 7;
  localparam int PRECHC   = 4;
  localparam int BUSYC    = SETUPC + RASLOC + PRECHC;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refMode = 1'b0;
  logic       seqIdle = 1'b0;
  logic       refBusy, closeReq, rasN, weN, ovfErr;
  logic [3:0] casN;
  logic [9:0] addr;
  logic [3:0] pendCount;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  refresh_sched #(
    .INTERVAL_CYC(INTERVAL), .PEND_MAX(PMAX), .ROW_BITS(10), .CAS_LINES(4),
    .SETUP_CYC(SETUPC), .RASLO_CYC(RASLOC), .PRECH_CYC(PRECHC)
  ) uut (
    .clk(clk), .rstN(rstN), .refMode(refMode), .seqIdle(seqIdle),
    .refBusy(refBusy), .closeReq(closeReq), .rasN(rasN), .casN(casN),
    .weN(weN), .addr(addr), .pendCount(pendCount), .ovfErr(ovfErr)
  );

  typedef struct packed {
    logic       mode;
    logic       flip;
    logic [9:0] expAddr;
    logic [3:0] expCas;
  } vec_t;

  // mode 1 = RAS-only, 0 = CAS-first; flip toggles refMode mid-refresh
  localparam vec_t VEC [0:5] = '{
    '{1'b1, 1'b0, 10'd0, 4'hF},
    '{1'b1, 1'b0, 10'd1, 4'hF},
    '{1'b0, 1'b0, 10'd0, 4'h0},
    '{1'b1, 1'b1, 10'd2, 4'hF},
    '{1'b0, 1'b1, 10'd0, 4'h0},
    '{1'b1, 1'b0, 10'd3, 4'hF}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic watchRefresh(input bit flip, output int busyLen, output int lowLen,
                              output logic [3:0] casFirst, output logic rasFirst,
                              output logic [3:0] casLow, output logic [9:0] addrLow,
                              output bit weLow);
    int guard = 0;
    while (!refBusy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    busyLen = 0; lowLen = 0; weLow = 0;
    casFirst = casN; rasFirst = rasN; casLow = 4'hx; addrLow = 10'h3FF;
    while (refBusy) begin
      busyLen++;
      if (!rasN) begin
        lowLen++;
        casLow = casN;
        addrLow = addr;
      end
      if (!weN) weLow = 1;
      if (flip && busyLen == 3) refMode = ~refMode;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int bl, ll;
    logic [3:0] cf, cl;
    logic rf;
    logic [9:0] al;
    bit wl;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(rasN == 1 && weN == 1 && refBusy == 0 && closeReq == 0, "R1 strobes", int'(rasN), 1);
    check(casN == 4'hF && addr == 0, "R1 bus", int'(casN), 15);
    check(pendCount == 0 && ovfErr == 0, "R1 counters", int'(pendCount), 0);

    // R2 timer period, sequencer busy
    rstN = 1'b1;
    repeat (INTERVAL - 1) @(negedge clk);
    check(pendCount == 0, "R2 before expiry", int'(pendCount), 0);
    @(negedge clk);
    check(pendCount == 1, "R2 first expiry", int'(pendCount), 1);
    repeat (INTERVAL * (PMAX - 1)) @(negedge clk);
    check(pendCount == PMAX, "R2 backlog", int'(pendCount), PMAX);
    check(refBusy == 0, "R5 no grant while busy", int'(refBusy), 0);
    check(closeReq == 1, "R6 close at cap", int'(closeReq), 1);
    check(ovfErr == 0, "R4 no error yet", int'(ovfErr), 0);
    repeat (INTERVAL) @(negedge clk);
    check(pendCount == PMAX, "R3 saturation", int'(pendCount), PMAX);
    check(ovfErr == 1, "R4 overflow", int'(ovfErr), 1);

    // R5 grant once idle
    seqIdle = 1'b1;
    @(negedge clk);
    check(refBusy == 1, "R5 grant", int'(refBusy), 1);
    check(pendCount == PMAX - 1, "R5 consume", int'(pendCount), PMAX - 1);
    check(closeReq == 0, "R6 close drops", int'(closeReq), 0);
    watchRefresh(0, bl, ll, cf, rf, cl, al, wl);
    check(bl == BUSYC, "R5 busy length", bl, BUSYC);
    // R11 backlog served back to back
    watchRefresh(0, bl, ll, cf, rf, cl, al, wl);
    check(bl == BUSYC && ll == RASLOC, "R11 next refresh", bl, BUSYC);
    check(ovfErr == 1, "R4 sticky", int'(ovfErr), 1);

    // Table of refresh styles
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    refMode = VEC[0].mode;
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      refMode = VEC[i].mode;
      watchRefresh(VEC[i].flip, bl, ll, cf, rf, cl, al, wl);
      check(bl == BUSYC, "R5 busy length", bl, BUSYC);
      check(ll == RASLOC, "R7/R8 RAS low length", ll, RASLOC);
      check(cf == VEC[i].expCas && rf == 1, "R7/R8 setup phase", int'(cf), int'(VEC[i].expCas));
      check(cl == VEC[i].expCas, "R10 CAS during RAS low", int'(cl), int'(VEC[i].expCas));
      check(al == VEC[i].expAddr, "R9 row address", int'(al), int'(VEC[i].expAddr));
      check(wl == 0, "R7 weN high", int'(wl), 0);
    end

    // R9 wrap after 1023
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    refMode = 1'b1;
    rstN = 1'b1;
    for (int i = 0; i < 1025; i++) begin
      watchRefresh(0, bl, ll, cf, rf, cl, al, wl);
      if (i == 1023) check(al == 10'd1023, "R9 last row", int'(al), 1023);
      if (i == 1024) check(al == 10'd0, "R9 wrap", int'(al), 0);
    end
    check(ovfErr == 0, "R4 no overflow when idle", int'(ovfErr), 0);

    finishRun();
  end

endmodule